// File: doc/BRIEF.md
# Cascadable Synchronous Loadable Binary Up-Counter

This block is a chain of identical binary up-counter slices, each `SLICE_W` bits wide, which together act as one synchronous counter of `SLICE_W * NUM_SLICES` bits. Every state bit changes only on the rising clock edge.

A zero on `clr_n` zeroes the count at the next edge. A zero on `load_n` copies the parallel word `din` into the count. Both of these ignore the two count enables. Counting needs both the parallel enable `en_p` and the trickle enable `en_t` to be high.

Each slice drives a carry term that is high when the slice is all ones and its trickle enable is high. That carry feeds the trickle enable of the next slice, while `en_p` goes to all slices. Wider counts therefore need no extra gating. The final carry leaves the block as `carry_out`.

Driving `clr_n` from an active-low decode of `q` shortens the count into a modulo-N sequence.

Top module: `sync_count_chain`

## Requirements
- R1: The count changes only at a rising edge of `clk`. Input changes between edges leave `q` unchanged.
- R2: When `clr_n` is 0 at a rising edge, `q` becomes 0, whatever `en_p` and `en_t` are.
- R3: When `clr_n` and `load_n` are both 0 at the same edge, clear wins and `q` becomes 0.
- R4: When `load_n` is 0 and `clr_n` is 1 at an edge, `q` takes `din`, whatever `en_p` and `en_t` are.
- R5: When `clr_n`, `load_n`, `en_p` and `en_t` are all 1 at an edge, `q` increases by one. All ones wraps to 0.
- R6: When `clr_n` and `load_n` are both 1 and either enable is 0, `q` keeps its value.
- R7: `carry_out` is 1 exactly when `en_t` is 1 and `q` is all ones. It follows `en_t` with no clock edge in between, and `en_p` has no effect on it.
- R8: The slices cascade through their carries, with the trickle enable of slice k driven by the carry of slice k-1. The whole chain counts as a single binary counter, including across slice boundaries and the wrap from all ones to 0.
- R9: If `clr_n` is driven as (`q` != T), the count runs 0, 1, ..., T and then returns to 0 on the edge after T is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_p | input | 1 | Parallel count enable, shared by all slices |
| en_t | input | 1 | Trickle count enable into the lowest slice; also gates the carry |
| din | input | SLICE_W*NUM_SLICES | Parallel load word |
| q | output | SLICE_W*NUM_SLICES | Current count |
| carry_out | output | 1 | High when `en_t` is high and `q` is all ones |

## Verification
The hardest case to reach from the ports is a carry rippling across all slice boundaries, ending in the wrap from all ones to 0. Random counting from zero would take thousands of cycles to get there. The stimulus therefore loads values just below each boundary (0x00F, 0x0FF, 0xFFD) and counts through them. It also holds the count at all ones while toggling `en_t` and `en_p` between edges, to show that the carry is combinational and depends only on `en_t`. The modulo configuration is produced by a decode in the bench that feeds `clr_n` from `q`. Long random runs with rare clears and loads are compared against an integer model.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } slice_op_e;

    // Priority: clear over load over count over hold.
    function automatic slice_op_e pick_op(
        input logic clr_n,
        input logic load_n,
        input logic en_p,
        input logic en_t
    );
        if (!clr_n)
            return OP_CLEAR;
        else if (!load_n)
            return OP_LOAD;
        else if (en_p && en_t)
            return OP_COUNT;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/cnt_carry.sv
module cnt_carry #(
    parameter int W = 4
) (
    input  logic [W-1:0] cnt,
    input  logic         en_t,
    output logic         rco
);
    // Combinational lookahead term: no register stage.
    assign rco = en_t & (&cnt);
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
    import cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic         en_p,
    input  logic         en_t,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         rco
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } slice_st_t;

    slice_st_t st_d, st_q;
    slice_op_e op;

    always_comb begin
        op   = pick_op(clr_n, load_n, en_p, en_t);
        st_d = st_q;
        unique case (op)
            OP_CLEAR: st_d.cnt = '0;
            OP_LOAD:  st_d.cnt = din;
            OP_COUNT: st_d.cnt = st_q.cnt + ONE;
            default:  st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.cnt;

    cnt_carry #(.W(W)) u_carry (
        .cnt  (st_q.cnt),
        .en_t (en_t),
        .rco  (rco)
    );

    // R2: clear zeroes the slice regardless of enables
    a_r2_clear: assert property (@(posedge clk) !clr_n |=> q == '0);
    // R3: clear has priority over load
    a_r3_clear_wins: assert property (@(posedge clk) (!clr_n && !load_n) |=> q == '0);
    // R4: load copies the data word
    a_r4_load: assert property (@(posedge clk) (clr_n && !load_n) |=> q == $past(din));
    // R5: increment with wrap
    a_r5_count: assert property (@(posedge clk)
        (clr_n && load_n && en_p && en_t) |=> q == W'($past(q) + ONE));
    // R6: hold when either enable is low
    a_r6_hold: assert property (@(posedge clk)
        (clr_n && load_n && !(en_p && en_t)) |=> $stable(q));
    // R7: an active carry while counting means the slice wraps to zero
    a_r7_carry_wrap: assert property (@(posedge clk)
        (rco && en_p && clr_n && load_n) |=> q == '0);
endmodule

// File: rtl/sync_count_chain.sv
module sync_count_chain #(
    parameter int SLICE_W    = 4,
    parameter int NUM_SLICES = 3
) (
    input  logic                          clk,
    input  logic                          clr_n,
    input  logic                          load_n,
    input  logic                          en_p,
    input  logic                          en_t,
    input  logic [SLICE_W*NUM_SLICES-1:0] din,
    output logic [SLICE_W*NUM_SLICES-1:0] q,
    output logic                          carry_out
);
    localparam int TOT_W = SLICE_W * NUM_SLICES;

    // R8: trickle enable of slice k is the carry of slice k-1
    logic [NUM_SLICES:0] t_chain;
    assign t_chain[0] = en_t;

    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
        cnt_slice #(.W(SLICE_W)) u_slice (
            .clk    (clk),
            .clr_n  (clr_n),
            .load_n (load_n),
            .en_p   (en_p),
            .en_t   (t_chain[k]),
            .din    (din[k*SLICE_W +: SLICE_W]),
            .q      (q[k*SLICE_W +: SLICE_W]),
            .rco    (t_chain[k+1])
        );
    end

    assign carry_out = t_chain[NUM_SLICES];

    // R7/R8: the chained carry implies a full all-ones count with en_t high
    a_r8_chain_carry: assert property (@(posedge clk) carry_out |-> (en_t && q == {TOT_W{1'b1}}));
    // R8: the whole chain increments as one counter
    a_r8_chain_count: assert property (@(posedge clk)
        (clr_n && load_n && en_p && en_t) |=> q == TOT_W'($past(q) + 1));
endmodule

// File: tb/tb_sync_count_chain.sv
`timescale 1ns/1ps
module tb_sync_count_chain;
    localparam int SW = 4;
    localparam int NS = 3;
    localparam int TW = SW * NS;
    localparam int unsigned MAXV = (1 << TW) - 1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          clr_drv, load_n, en_p, en_t, mod_mode;
    logic [TW-1:0] din, q;
    logic          carry_out, clr_n;
    int unsigned   term;

    assign clr_n = mod_mode ? (q != TW'(term)) : clr_drv;

    sync_count_chain #(.SLICE_W(SW), .NUM_SLICES(NS)) dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
        .din(din), .q(q), .carry_out(carry_out)
    );

    int checks = 0;
    int errors = 0;
    int unsigned model;

    function automatic int unsigned next_val(int unsigned cur, bit c, bit l, bit p, bit t, int unsigned d);
        if (!c) return 0;
        if (!l) return d & MAXV;
        if (p && t) return (cur + 1) & MAXV;
        return cur;
    endfunction

    function automatic int unsigned exp_carry(int unsigned cur, bit t);
        return (t && cur == MAXV) ? 1 : 0;
    endfunction

    task automatic check(string tag, int unsigned act, int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(bit c, bit l, bit p, bit t, int unsigned d, string tag);
        bit ce;
        @(negedge clk);
        clr_drv = c; load_n = l; en_p = p; en_t = t; din = TW'(d);
        #1;
        check("R1 no change between edges", q, model);
        check("R7 carry", carry_out, exp_carry(model, t));
        ce = mod_mode ? (model != term) : c;
        model = next_val(model, ce, l, p, t, d);
        @(posedge clk); #1;
        check(tag, q, model);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        mod_mode = 1'b0; term = 0;
        clr_drv = 1'b0; load_n = 1'b1; en_p = 1'b1; en_t = 1'b1; din = '0;
        @(posedge clk); #1;
        model = 0;
        check("R2 initial clear", q, 0);

        step(1, 0, 0, 0, 12'h3C7, "R4 load enables low");
        step(0, 1, 1, 1, 0, "R2 clear enables high");
        step(1, 0, 1, 1, 12'h5A5, "R4 load");
        step(0, 0, 1, 1, 12'hABC, "R3 clear wins over load");
        step(1, 0, 1, 1, 12'h123, "R4 load enables high");
        step(1, 1, 0, 1, 0, "R6 hold en_p low");
        step(1, 1, 1, 0, 0, "R6 hold en_t low");
        for (int i = 0; i < 5; i++) step(1, 1, 1, 1, 0, "R5 count");

        step(1, 0, 0, 0, 12'h00F, "R4 load");
        step(1, 1, 1, 1, 0, "R8 carry into slice 1");
        step(1, 0, 0, 0, 12'h0FF, "R4 load");
        step(1, 1, 1, 1, 0, "R8 carry into slice 2");
        step(1, 0, 0, 0, 12'hFFD, "R4 load");
        for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 0, "R8 chain count and wrap");

        step(1, 0, 0, 0, 12'hFFF, "R4 load all ones");
        step(1, 1, 1, 0, 0, "R7 en_t low holds");
        step(1, 1, 0, 1, 0, "R7 en_p low carry");
        step(1, 1, 0, 0, 0, "R7 carry off");
        step(1, 1, 1, 1, 0, "R5 wrap to zero");

        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 99) >= 3, $urandom_range(0, 99) >= 5,
                 $urandom_range(0, 9) >= 2, $urandom_range(0, 9) >= 2,
                 $urandom_range(0, MAXV), "R5 random");
        end

        step(1, 0, 0, 0, 0, "R4 load zero");
        term = 9; mod_mode = 1'b1;
        for (int i = 0; i < 40; i++) step(1, 1, 1, 1, 0, "R9 modulo 10");
        term = 5;
        for (int i = 0; i < 20; i++) step(1, 1, 1, 1, 0, "R9 modulo 6");
        mod_mode = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule